// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous single-port memory with a late-write pipeline. The bus carries one command per clock. A read command's data leaves the block two enabled clock edges after the command. A write command's data is taken from the data input two enabled edges after the write command, which is the same distance. Reads and writes can therefore follow each other in any order with no idle cycles on the shared data bus. The storage is a small parameterised register array split into byte lanes.

Every command edge either loads a new operation or advances a burst. A load takes the address, the three chip selects and the read/write flag from the pins. An advance ignores those pins: it repeats the previous operation type and steps a 2-bit counter over the two low address bits, in linear or interleaved order. A stall input freezes the whole block, including any operations already in the pipeline. The output side gives a registered data word and a driver-enable signal. The pad-level tristate buffer outside the block uses these two signals, and the output-enable input gates the driver enable asynchronously.

A write can still be waiting for its data when a read of the same word is in the array-read stage. In that case the read takes the lanes that the write enables straight from the incoming data, so it never returns stale array contents.

Top module: `zt_sram`

## Requirements
- R1: A read command loaded at enabled edge k (all selects active, `adv_step`=0, `rd_wr_n`=1) raises `q_en` and presents the addressed word on `q_out` after enabled edge k+2, and not before.
- R2: For a write command (`rd_wr_n`=0) loaded at enabled edge k, `d_in` is captured at enabled edge k+2. Lane i (bits i*9+8 down to i*9) is written only when `lane_we_n[i]` was 0 at edge k, and a lane whose enable was 1 keeps its old contents.
- R3: A read issued on the edge directly after a write to the same address returns the newly written lanes merged with the old contents of the other lanes, in any read/write mix with no idle cycles.
- R4: With `adv_step`=1, the address, chip selects and `rd_wr_n` pins are ignored and the previous operation type (read, write or deselect) continues. The lane enables are still sampled on every edge.
- R5: With `ilv_order`=1, advance step n (n=1..3, mod 4) uses low bits start XOR n. With `ilv_order`=0 it uses (start + n) mod 4.
- R6: During a burst the address bits above bit 1 stay equal to the loaded address, even past four beats.
- R7: While `stall`=1, no register changes state: outputs hold, pending writes wait and `d_in` is not captured.
- R8: A load with `sel0_n`=1, `sel1`=0 or `sel2_n`=1 is a deselect. `q_en` falls two enabled edges later, and reads or writes already in flight still complete.
- R9: `oe_n`=1 forces `q_en` low at once, with no clock edge, and `oe_n`=0 restores it.
- R10: Asserting `rst_n` low clears every pending operation and drops `q_en` immediately. After release, the block stays idle until new commands arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| stall | input | 1 | 1 freezes all state for this edge |
| sel0_n | input | 1 | Chip select, active low, sampled on load |
| sel1 | input | 1 | Chip select, active high, sampled on load |
| sel2_n | input | 1 | Chip select, active low, sampled on load |
| adv_step | input | 1 | 1 advances the burst, 0 loads a new command |
| rd_wr_n | input | 1 | 1 read, 0 write, sampled on load |
| lane_we_n | input | LANES | Per-lane write enable, active low, sampled every edge |
| addr | input | AW | Word address, sampled on load |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear; held static during bursts |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LW | Write data from the pad |
| q_out | output | LANES*LW | Registered read data to the pad |
| q_en | output | 1 | Pad driver enable |

## Verification
The bench aims at a read placed directly behind a partial-lane write to the same word. A design without the forwarding merge would return the old word there, and one with a wrong lane mask would mix up the halves. It runs bursts in both orders from non-zero start offsets and past four beats. A wrong order or a carry into the upper bits would show up as reads of wrong words. It also stalls while writes wait for data, deselects behind in-flight reads and writes, and resets with a read pending. A design that captured data on a stalled edge, cut off in-flight work or kept driving after reset would show wrong data or a wrong `q_en`.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr
  import zt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          ilv,
  input  logic [AW-1:0] ld_addr,
  input  op_e           ld_kind,
  output logic [AW-1:0] cmd_addr,
  output op_e           cmd_kind
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q, hi_nx;
  logic [1:0]    start_q, start_nx, step_q, step_nx, step_inc, lo_adv;
  op_e           kind_q, kind_nx;

  always_comb begin
    step_inc = step_q + 2'd1;
    lo_adv   = ilv ? (start_q ^ step_inc) : (start_q + step_inc);
    if (adv) begin
      cmd_addr = {hi_q, lo_adv};
      cmd_kind = kind_q;
    end else begin
      cmd_addr = ld_addr;
      cmd_kind = ld_kind;
    end
  end

  always_comb begin
    hi_nx    = hi_q;
    start_nx = start_q;
    step_nx  = step_q;
    kind_nx  = kind_q;
    if (en) begin
      if (adv) begin
        step_nx = step_inc;
      end else begin
        hi_nx    = ld_addr[AW-1:2];
        start_nx = ld_addr[1:0];
        step_nx  = 2'd0;
        kind_nx  = ld_kind;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      step_q  <= '0;
      kind_q  <= OP_NONE;
    end else begin
      hi_q    <= hi_nx;
      start_q <= start_nx;
      step_q  <= step_nx;
      kind_q  <= kind_nx;
    end
  end
endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES-1:0]    wr_be_n,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_nx;
  logic [DW-1:0] rd_merged;

  // forwarding merge: lanes of the write committing this edge win
  always_comb begin
    rd_merged = mem[rd_addr];
    for (int l = 0; l < LANES; l++) begin
      if (wr_en && (wr_addr == rd_addr) && !wr_be_n[l])
        rd_merged[l*LW +: LW] = wr_data[l*LW +: LW];
    end
    rd_nx = (en && rd_en) ? rd_merged : rd_q;
  end

  always_ff @(posedge clk) begin
    if (en && wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wr_be_n[l]) mem[wr_addr][l*LW +: LW] <= wr_data[l*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nx;
  end

  // R3: a same-address pending write's enabled low lane reaches the read register
  a_r3_forward_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_en && wr_en && (wr_addr == rd_addr) && !wr_be_n[0])
      |=> (rd_q[LW-1:0] == $past(wr_data[LW-1:0])));
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                sel0_n,
  input  logic                sel1,
  input  logic                sel2_n,
  input  logic                adv_step,
  input  logic                rd_wr_n,
  input  logic [LANES-1:0]    lane_we_n,
  input  logic [AW-1:0]       addr,
  input  logic                ilv_order,
  input  logic                oe_n,
  input  logic [LANES*LW-1:0] d_in,
  output logic [LANES*LW-1:0] q_out,
  output logic                q_en
);
  localparam int DW = LANES * LW;

  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic          en;
  logic          selected;
  op_e           ld_kind, cmd_kind;
  logic [AW-1:0] cmd_addr;

  assign en = !stall;

  always_comb begin
    selected = !sel0_n && sel1 && !sel2_n;
    if (!selected)    ld_kind = OP_NONE;
    else if (rd_wr_n) ld_kind = OP_RD;
    else              ld_kind = OP_WR;
  end

  zt_burst_ctr #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en),
    .adv      (adv_step),
    .ilv      (ilv_order),
    .ld_addr  (addr),
    .ld_kind  (ld_kind),
    .cmd_addr (cmd_addr),
    .cmd_kind (cmd_kind)
  );

  op_e              s1_kind, s1_kind_nx, s2_kind, s2_kind_nx;
  logic [AW-1:0]    s1_addr, s1_addr_nx, s2_addr, s2_addr_nx;
  logic [LANES-1:0] s1_be, s1_be_nx, s2_be, s2_be_nx;
  logic             out_v, out_v_nx;
  logic [DW-1:0]    out_d, out_d_nx, rd_q;

  zt_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
    .clk     (clk),
    .rst_n   (rst_q),
    .en      (en),
    .wr_en   (s2_kind == OP_WR),
    .wr_addr (s2_addr),
    .wr_be_n (s2_be),
    .wr_data (d_in),
    .rd_en   (s1_kind == OP_RD),
    .rd_addr (s1_addr),
    .rd_q    (rd_q)
  );

  always_comb begin
    s1_kind_nx = s1_kind;
    s1_addr_nx = s1_addr;
    s1_be_nx   = s1_be;
    s2_kind_nx = s2_kind;
    s2_addr_nx = s2_addr;
    s2_be_nx   = s2_be;
    out_v_nx   = out_v;
    out_d_nx   = out_d;
    if (en) begin
      s1_kind_nx = cmd_kind;
      s1_addr_nx = cmd_addr;
      s1_be_nx   = lane_we_n;
      s2_kind_nx = s1_kind;
      s2_addr_nx = s1_addr;
      s2_be_nx   = s1_be;
      out_v_nx   = (s2_kind == OP_RD);
      if (s2_kind == OP_RD) out_d_nx = rd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_kind <= OP_NONE;
      s1_addr <= '0;
      s1_be   <= '1;
      s2_kind <= OP_NONE;
      s2_addr <= '0;
      s2_be   <= '1;
      out_v   <= 1'b0;
      out_d   <= '0;
    end else begin
      s1_kind <= s1_kind_nx;
      s1_addr <= s1_addr_nx;
      s1_be   <= s1_be_nx;
      s2_kind <= s2_kind_nx;
      s2_addr <= s2_addr_nx;
      s2_be   <= s2_be_nx;
      out_v   <= out_v_nx;
      out_d   <= out_d_nx;
    end
  end

  assign q_out = out_d;
  assign q_en  = out_v && !oe_n;

  // R1: a read in the last stage drives the bus after the next enabled edge
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_q)
    (en && s2_kind == OP_RD) |=> out_v);

  // R8: anything but a read leaving the pipe releases the bus
  a_r8_idle_releases: assert property (@(posedge clk) disable iff (!rst_q)
    (en && s2_kind != OP_RD) |=> !out_v);

  // R7: a stalled edge changes neither output state nor the first stage
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_q)
    stall |=> ($stable(out_v) && $stable(out_d) && $stable(s1_addr) && $stable(s1_kind)));

  // R4: an advance repeats the operation type of the previous command
  a_r4_advance_keeps_kind: assert property (@(posedge clk) disable iff (!rst_q)
    (en && adv_step) |=> (s1_kind == $past(s1_kind)));

  // R6: an advance never changes the address bits above the burst field
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_q)
    (en && adv_step) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW    = 6;
  localparam int LANES = 2;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stall;
  logic             sel0_n, sel1, sel2_n;
  logic             adv_step, rd_wr_n;
  logic [LANES-1:0] lane_we_n;
  logic [AW-1:0]    addr;
  logic             ilv_order, oe_n;
  logic [DW-1:0]    d_in;
  logic [DW-1:0]    q_out;
  logic             q_en;

  always #5 clk = ~clk;

  zt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .adv_step(adv_step), .rd_wr_n(rd_wr_n),
    .lane_we_n(lane_we_n), .addr(addr), .ilv_order(ilv_order), .oe_n(oe_n),
    .d_in(d_in), .q_out(q_out), .q_en(q_en)
  );

  typedef struct {
    int             kind;   // 0 deselect, 1 read, 2 write
    int             a;
    logic [LANES-1:0] be;
  } mop_t;

  int            checks = 0;
  int            errors = 0;
  string         tag;
  logic [DW-1:0] mref [DEPTH];
  mop_t          pend[$];
  int            b_base, b_st, b_step, b_kind;
  logic          exp_v;
  logic [DW-1:0] exp_d;
  int            wctr = 0;

  task automatic model_reset();
    mop_t idle_op;
    idle_op.kind = 0; idle_op.a = 0; idle_op.be = '1;
    pend.delete();
    pend.push_back(idle_op);
    pend.push_back(idle_op);
    b_base = 0; b_st = 0; b_step = 0; b_kind = 0;
    exp_v = 1'b0;
    exp_d = '0;
  endtask

  task automatic check_out();
    logic want;
    want = exp_v && !oe_n;
    checks++;
    if (q_en !== want || (want && q_out !== exp_d)) begin
      errors++;
      $display("FAIL %s: q_en=%b q_out=%h expected q_en=%b q_out=%h",
               tag, q_en, q_out, want, exp_d);
    end
  endtask

  // one clock: model the command about to be sampled, then compare at negedge
  task automatic tick();
    mop_t cmd, done;
    if (!stall) begin
      if (!adv_step) begin
        b_base = int'(addr);
        b_st   = int'(addr) & 3;
        b_step = 0;
        b_kind = (!sel0_n && sel1 && !sel2_n) ? (rd_wr_n ? 1 : 2) : 0;
        cmd.a  = int'(addr);
      end else begin
        b_step = (b_step + 1) & 3;
        cmd.a  = (b_base & ~3) | (ilv_order ? (b_st ^ b_step) : ((b_st + b_step) & 3));
      end
      cmd.kind = b_kind;
      cmd.be   = lane_we_n;
      done = pend.pop_front();
      pend.push_back(cmd);
      if (done.kind == 2) begin
        wctr++;
        d_in = DW'((wctr * 2731 + 77) & 32'h1FFFF);
        for (int l = 0; l < LANES; l++)
          if (!done.be[l]) mref[done.a][l*LW +: LW] = d_in[l*LW +: LW];
      end else begin
        d_in = 18'h15555;
      end
      if (done.kind == 1) begin
        exp_v = 1'b1;
        exp_d = mref[done.a];
      end else begin
        exp_v = 1'b0;
      end
    end else begin
      d_in = 18'h0F0F0;
    end
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic load(input int kind, input int a, input logic [LANES-1:0] be);
    adv_step  = 1'b0;
    sel0_n    = (kind == 0);
    sel1      = 1'b1;
    sel2_n    = 1'b0;
    rd_wr_n   = (kind != 2);
    addr      = AW'(a);
    lane_we_n = be;
    tick();
  endtask

  // advance with misleading address, selects and direction on the pins (R4)
  task automatic advance(input logic [LANES-1:0] be);
    adv_step  = 1'b1;
    sel0_n    = 1'b1;
    sel1      = 1'b0;
    sel2_n    = 1'b1;
    rd_wr_n   = ~rd_wr_n;
    addr      = ~addr;
    lane_we_n = be;
    tick();
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; stall = 1'b0; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
    adv_step = 1'b0; rd_wr_n = 1'b1; lane_we_n = '1; addr = '0;
    ilv_order = 1'b0; oe_n = 1'b0; d_in = '0;
    model_reset();
    #2 rst_n = 1'b0;
    #1;
    tag = "R10 reset state";
    checks++;
    if (q_en !== 1'b0) begin
      errors++;
      $display("FAIL R10: q_en=%b expected 0", q_en);
    end
    repeat (3) load(0, 0, '1);
    rst_n = 1'b1;
    repeat (3) load(0, 0, '1);

    tag = "R2 full writes";
    for (int a = 0; a < DEPTH; a++) load(2, a, 2'b00);
    tag = "R1 reads";
    for (int a = 0; a < 6; a++) load(1, a, '1);
    load(0, 0, '1); load(0, 0, '1);

    tag = "R3 forward lane0";
    load(2, 5, 2'b10); load(1, 5, '1); load(1, 6, '1);
    tag = "R3 forward lane1";
    load(2, 7, 2'b01); load(1, 7, '1);
    tag = "R2 no lanes enabled";
    load(2, 8, 2'b11); load(1, 8, '1);
    tag = "R3 mixed";
    load(2, 9, 2'b00); load(1, 9, '1); load(2, 10, 2'b00); load(1, 9, '1);
    load(1, 10, '1); load(2, 9, 2'b01); load(1, 9, '1);
    load(0, 0, '1); load(0, 0, '1);

    tag = "R5 linear burst";
    ilv_order = 1'b0;
    load(2, 14, 2'b00); advance(2'b00); advance(2'b01); advance(2'b10);
    load(1, 14, '1); advance('1); advance('1); advance('1);
    tag = "R6 long burst";
    load(1, 23, '1);
    for (int i = 0; i < 6; i++) advance('1);
    load(0, 0, '1); load(0, 0, '1);

    tag = "R5 interleaved burst";
    ilv_order = 1'b1;
    load(0, 0, '1);
    load(2, 21, 2'b00); advance(2'b00); advance(2'b10); advance(2'b00);
    load(1, 21, '1); advance('1); advance('1); advance('1);
    tag = "R4 burst continues";
    load(1, 42, '1);
    for (int i = 0; i < 5; i++) advance('1);
    load(0, 0, '1); load(0, 0, '1);
    ilv_order = 1'b0;
    load(0, 0, '1);

    tag = "R7 stall";
    load(2, 30, 2'b00); load(1, 31, '1);
    stall = 1'b1;
    load(2, 1, 2'b00); load(1, 2, '1); advance(2'b00);
    stall = 1'b0;
    load(1, 30, '1); advance('1);
    stall = 1'b1;
    advance('1); advance('1);
    stall = 1'b0;
    advance('1); load(0, 0, '1); load(0, 0, '1);

    tag = "R8 deselect";
    load(1, 3, '1);
    sel0_n = 1'b1; sel1 = 1'b1; sel2_n = 1'b0; adv_step = 1'b0; tick();
    load(1, 4, '1);
    sel0_n = 1'b0; sel1 = 1'b0; sel2_n = 1'b0; tick();
    load(2, 33, 2'b00);
    sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b1; tick();
    advance('1); advance('1);
    load(1, 33, '1); load(0, 0, '1); load(0, 0, '1);

    tag = "R9 output enable";
    load(1, 2, '1); load(0, 0, '1); load(0, 0, '1);
    oe_n = 1'b1;
    #1;
    checks++;
    if (q_en !== 1'b0) begin
      errors++;
      $display("FAIL R9: q_en=%b expected 0 with oe_n high", q_en);
    end
    oe_n = 1'b0;
    #1;
    checks++;
    if (q_en !== 1'b1) begin
      errors++;
      $display("FAIL R9: q_en=%b expected 1 after oe_n low", q_en);
    end
    load(0, 0, '1); load(0, 0, '1);

    tag = "R10 reset in flight";
    load(2, 40, 2'b00); load(1, 1, '1); load(1, 2, '1);
    rst_n = 1'b0;
    #1;
    checks++;
    if (q_en !== 1'b0) begin
      errors++;
      $display("FAIL R10: q_en=%b expected 0 during reset", q_en);
    end
    model_reset();
    load(0, 0, '1); load(0, 0, '1);
    rst_n = 1'b1;
    repeat (4) load(0, 0, '1);
    load(1, 40, '1); load(1, 1, '1); load(0, 0, '1); load(0, 0, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule